// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port

This block is one general-purpose I/O port of eight pins behind a small register bus. Software sets which pins are inputs and which are outputs, writes the levels that output pins drive, reads back the levels actually present on the pins, and switches on weak pull-ups for selected input pins. On the pad side, the block gives each pin an output-enable, an output-data bit and a pull-up enable, and it takes one input level per pin from the pad cell.

Pin levels pass through a two-stage synchronizer before they can be read, so a read shows the pins as they stood two clocks earlier. The output latch can be read at its own address, separate from the pin-level address. This lets software do a read-modify-write on the latch without picking up a pin that an external load holds at the wrong level. Writes to the pin-level address land in the output latch. Pull-ups need two conditions: an active-low global control bit must be cleared, and the pin's bit must be set in a select mask. A pull-up is never applied to a pin that is driving.

Top module: `gpio_port8`

## Requirements
- R1: After reset, pad_oe, pad_out and pad_pu are all 0. Reads return 0xFF from the direction register (address 0), 0x00 from the latch (address 2), 0x00 from the pull-up select mask (address 3) and 0x01 from the pull-up control (address 4, bit 0 = pull-up disable).
- R2: Direction bit i = 1 makes pin i an input (pad_oe[i] = 0). Direction bit i = 0 makes pin i an output (pad_oe[i] = 1). A write to address 0 changes pad_oe on the clock edge that samples the write strobe.
- R3: pad_out carries the output latch bit for bit. A pin configured as an output therefore drives its latch bit onto the pad.
- R4: A read of address 1 returns the pad levels after the synchronizer. A level presented before clock edge k can be read after edge k+1 and not after edge k. The read shows the pin, not the latch.
- R5: A write to address 1 updates the output latch in exactly the same way as a write to address 2.
- R6: A read of address 2 returns the latch contents even while the pins show a different level. A read-modify-write through address 2 therefore keeps every latch bit it does not change.
- R7: pad_pu[i] is 1 exactly when bit 0 of address 4 is 0, bit i of address 3 is 1 and pin i is an input.
- R8: Addresses 5 to 7 read as 0, and writes to them change no register and no pad output.
- R9: bus_rdata depends only on the current address and register contents. It follows a change of bus_addr within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| pad_in | input | 8 | Levels seen on the pads |
| pad_oe | output | 8 | Per-pin output-driver enable |
| pad_out | output | 8 | Per-pin output level |
| pad_pu | output | 8 | Per-pin weak pull-up enable |

## Verification
Register writes and the pad controls that follow from them are due on the first clock edge after the write strobe is presented. The bench drives every write at a falling edge and checks the result at the next falling edge. Register reads are due in the same cycle, so the bench changes the address and samples bus_rdata a moment later, with no edge in between. Pin levels are due only after the second rising edge following a change. The bench changes the external level at a falling edge and checks that the old value is still read after one edge and the new one after two. For pull-up results it waits two edges beyond the control write.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_DIR   = 3'd0,
        A_PIN   = 3'd1,
        A_LAT   = 3'd2,
        A_PUSEL = 3'd3,
        A_PUCTL = 3'd4
    } reg_addr_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stage;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d          = sync_q;
        sync_d.stage[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            sync_d.stage[s] = sync_q.stage[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_out = sync_q.stage[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      lat_q,
    output logic [W-1:0]      pusel_q,
    output logic              pudis_q
);

    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] lat;
        logic [W-1:0] pusel;
        logic         pudis;
    } regs_t;

    localparam regs_t RESET_VAL = '{dir: '1, lat: '0, pusel: '0, pudis: 1'b1};

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr) begin
            case (addr)
                A_DIR:          regs_d.dir   = wdata;
                A_PIN, A_LAT:   regs_d.lat   = wdata;   // pin address aliases the latch on write
                A_PUSEL:        regs_d.pusel = wdata;
                A_PUCTL:        regs_d.pudis = wdata[0];
                default:        regs_d       = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= RESET_VAL;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign dir_q   = regs_q.dir;
    assign lat_q   = regs_q.lat;
    assign pusel_q = regs_q.pusel;
    assign pudis_q = regs_q.pudis;

endmodule

// File: rtl/gpio_padctl.sv
module gpio_padctl (
    input  logic dir_in,
    input  logic lat_bit,
    input  logic pusel_bit,
    input  logic pu_disable,
    output logic oe,
    output logic dout,
    output logic pu
);

    always_comb begin
        oe   = ~dir_in;
        dout = lat_bit;
        pu   = ~pu_disable & pusel_bit & dir_in;
    end

endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      dir_q,
    input  logic [W-1:0]      pin_sync,
    input  logic [W-1:0]      lat_q,
    input  logic [W-1:0]      pusel_q,
    input  logic              pudis_q,
    output logic [W-1:0]      rdata
);

    always_comb begin
        case (addr)
            A_DIR:   rdata = dir_q;
            A_PIN:   rdata = pin_sync;
            A_LAT:   rdata = lat_q;
            A_PUSEL: rdata = pusel_q;
            A_PUCTL: rdata = {{(W-1){1'b0}}, pudis_q};
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_port8.sv
module gpio_port8
    import gpio_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_oe,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_pu
);

    logic [W-1:0] dir_q;
    logic [W-1:0] lat_q;
    logic [W-1:0] pusel_q;
    logic         pudis_q;
    logic [W-1:0] pin_sync;

    gpio_regs #(.W(W)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .wr      (bus_wr),
        .wdata   (bus_wdata),
        .dir_q   (dir_q),
        .lat_q   (lat_q),
        .pusel_q (pusel_q),
        .pudis_q (pudis_q)
    );

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    for (genvar i = 0; i < W; i++) begin : g_pin
        gpio_padctl i_pad (
            .dir_in     (dir_q[i]),
            .lat_bit    (lat_q[i]),
            .pusel_bit  (pusel_q[i]),
            .pu_disable (pudis_q),
            .oe         (pad_oe[i]),
            .dout       (pad_out[i]),
            .pu         (pad_pu[i])
        );
    end

    gpio_rdmux #(.W(W)) i_rdmux (
        .addr     (bus_addr),
        .dir_q    (dir_q),
        .pin_sync (pin_sync),
        .lat_q    (lat_q),
        .pusel_q  (pusel_q),
        .pudis_q  (pudis_q),
        .rdata    (bus_rdata)
    );

endmodule

// File: rtl/gpio_port8_chk.sv
module gpio_port8_chk
    import gpio_pkg::*;
#(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      bus_rdata,
    input logic [W-1:0]      pad_in,
    input logic [W-1:0]      pad_oe,
    input logic [W-1:0]      pad_out,
    input logic [W-1:0]      pad_pu
);

    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd2) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DIR) |=> (pad_oe == ~$past(bus_wdata)));

    assert_latch_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == A_PIN || bus_addr == A_LAT)) |=> (pad_out == $past(bus_wdata)));

    assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == A_PIN || bus_addr == A_LAT)) |=> $stable(pad_out));

    assert_no_pu_on_driver_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);

    assert_pin_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2 && bus_addr == A_PIN) |-> (bus_rdata == $past(pad_in, 2)));

    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > A_PUCTL) |-> (bus_rdata == '0));

endmodule

bind gpio_port8 gpio_port8_chk #(.W(W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pad_pu    (pad_pu)
);

// File: tb/test_gpio_port8.sv
`timescale 1ns/1ps
module test_gpio_port8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in;
    logic [7:0] pad_oe;
    logic [7:0] pad_out;
    logic [7:0] pad_pu;

    logic [7:0] ext_en  = '0;
    logic [7:0] ext_val = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    // Pad net model: the block's driver wins, then an external driver, then the
    // weak pull-up; an undriven pin with no pull-up settles low.
    always_comb begin
        for (int i = 0; i < 8; i++) begin
            if (pad_oe[i])      pad_in[i] = pad_out[i];
            else if (ext_en[i]) pad_in[i] = ext_val[i];
            else if (pad_pu[i]) pad_in[i] = 1'b1;
            else                pad_in[i] = 1'b0;
        end
    end

    gpio_port8 i_gpio_port8 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out),
        .pad_pu    (pad_pu)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic read_reg(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_out", pad_out, 8'h00);
        check("R1 pad_pu", pad_pu, 8'h00);
        read_reg(3'd0, v); check("R1 dir", v, 8'hFF);
        read_reg(3'd2, v); check("R1 lat", v, 8'h00);
        read_reg(3'd3, v); check("R1 pusel", v, 8'h00);
        read_reg(3'd4, v); check("R1 puctl", v, 8'h01);
    endtask

    task automatic t_direction;
        logic [7:0] v;
        write_reg(3'd0, 8'hF0);
        check("R2 oe after dir F0", pad_oe, 8'h0F);
        read_reg(3'd0, v); check("R2 dir readback", v, 8'hF0);
        write_reg(3'd0, 8'h5A);
        check("R2 oe after dir 5A", pad_oe, 8'hA5);
        // R9: address change alone moves rdata within the cycle
        read_reg(3'd0, v); check("R9 rdata dir", v, 8'h5A);
        read_reg(3'd4, v); check("R9 rdata puctl", v, 8'h01);
    endtask

    task automatic t_latch;
        logic [7:0] v;
        write_reg(3'd0, 8'h00);
        write_reg(3'd2, 8'hA5);
        check("R3 pad_out from lat", pad_out, 8'hA5);
        read_reg(3'd2, v); check("R6 lat readback", v, 8'hA5);
        write_reg(3'd1, 8'h3C);
        check("R5 pin-addr write to pad_out", pad_out, 8'h3C);
        read_reg(3'd2, v); check("R5 pin-addr write to lat", v, 8'h3C);
        @(negedge clk); @(negedge clk);
        read_reg(3'd1, v); check("R3 driven pin loops back", v, 8'h3C);
    endtask

    task automatic t_rmw;
        logic [7:0] v;
        write_reg(3'd0, 8'hFF);
        ext_en  = 8'hFF;
        ext_val = 8'h00;
        write_reg(3'd2, 8'hFF);
        @(negedge clk); @(negedge clk);
        read_reg(3'd1, v); check("R4 pin shows external level", v, 8'h00);
        read_reg(3'd2, v); check("R6 lat differs from pin", v, 8'hFF);
        write_reg(3'd2, v & 8'hFE);
        read_reg(3'd2, v); check("R6 rmw keeps other bits", v, 8'hFE);
    endtask

    task automatic t_pin_sync;
        logic [7:0] v;
        @(negedge clk);
        ext_val = 8'h5A;
        @(negedge clk);
        read_reg(3'd1, v); check("R4 one edge: old value", v, 8'h00);
        @(negedge clk);
        read_reg(3'd1, v); check("R4 two edges: new value", v, 8'h5A);
        ext_val = 8'hC3;
        @(negedge clk); @(negedge clk);
        read_reg(3'd1, v); check("R4 second pattern", v, 8'hC3);
    endtask

    task automatic t_pullup;
        logic [7:0] v;
        ext_en = 8'h00;
        write_reg(3'd0, 8'hFF);
        write_reg(3'd3, 8'h0F);
        check("R7 global disable blocks pull-up", pad_pu, 8'h00);
        @(negedge clk);
        read_reg(3'd1, v); check("R7 floating pins low", v, 8'h00);
        write_reg(3'd4, 8'h00);
        check("R7 pull-ups on selected pins", pad_pu, 8'h0F);
        @(negedge clk); @(negedge clk);
        read_reg(3'd1, v); check("R7 pulled pins read high", v, 8'h0F);
        write_reg(3'd0, 8'hFC);
        check("R7 pull-up off on outputs", pad_pu, 8'h0C);
        read_reg(3'd3, v); check("R7 pusel readback", v, 8'h0F);
        read_reg(3'd4, v); check("R7 puctl readback", v, 8'h00);
    endtask

    task automatic t_unmapped;
        logic [7:0] v;
        logic [7:0] oe0, out0, pu0;
        oe0 = pad_oe; out0 = pad_out; pu0 = pad_pu;
        write_reg(3'd5, 8'hFF);
        write_reg(3'd6, 8'h00);
        write_reg(3'd7, 8'h81);
        check("R8 pad_oe unchanged", pad_oe, oe0);
        check("R8 pad_out unchanged", pad_out, out0);
        check("R8 pad_pu unchanged", pad_pu, pu0);
        read_reg(3'd5, v); check("R8 addr5 reads 0", v, 8'h00);
        read_reg(3'd6, v); check("R8 addr6 reads 0", v, 8'h00);
        read_reg(3'd7, v); check("R8 addr7 reads 0", v, 8'h00);
        read_reg(3'd0, v); check("R8 dir unchanged", v, 8'hFC);
        read_reg(3'd2, v); check("R8 lat unchanged", v, 8'hFE);
        read_reg(3'd3, v); check("R8 pusel unchanged", v, 8'h0F);
        read_reg(3'd4, v); check("R8 puctl unchanged", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direction();
        t_latch();
        t_rmw();
        t_pin_sync();
        t_pullup();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule